// File: doc/BRIEF.md
# Audio Serial Bus Master Clock Generator

This block produces the bit clock and the word clock of an audio serial bus whenever the device drives those lines itself. A two-bit select picks one of three source clocks. Each source arrives as a single-cycle tick on the system clock, and every tick marks one edge of that source. The bit clock is the selected source divided by a 7-bit ratio. The word clock is a second division, this time counting bit-clock periods. It stays low for the first half of the frame and high for the second half.

Each clock line has four controls of its own: a master/slave select, a divider power enable and an edge-inversion bit, plus a pin output enable. The output enable is high only while that line is master and its divider is powered, so the pin floats when the interface is powered down. When the bit line is slave, the word divider counts rising edges of the externally supplied bit clock instead of the internal one. A word ratio code in the reserved band forces the word clock low and sets a sticky error flag.

Top module: `serial_clock_master`

## Requirements
- R1: After reset, with all configuration inputs low, bclk_o, wclk_o, bclk_oe, wclk_oe and wdiv_err are all 0.
- R2: src_sel chooses the tick source as follows: 2'b00 takes dac_tick, 2'b01 takes adc_tick and 2'b10 takes ndiv_tick. With 2'b11 no tick is counted, so the bit clock holds its level.
- R3: While bdiv_pwr is 1, the bit clock level toggles after every N selected ticks. N is bdiv_code, and code 0 means 128. The toggle shows on the clock edge that samples the N-th tick.
- R4: While bdiv_pwr is 0, the bit-clock level is 0 and its count is cleared. After power-up, the first half period is N full ticks.
- R5: While wdiv_pwr is 1 and the code is valid, the word clock changes only on a bit-clock rising edge. A frame is M bit periods, with M equal to wdiv_code and code 0 meaning 128. The level is low for M minus floor(M/2) bit periods and then high for floor(M/2) bit periods. While wdiv_pwr is 0, the level is 0 and the count is cleared.
- R6: Codes 1 through 31 on wdiv_code are reserved. While wdiv_pwr is 1 with a reserved code, the word-clock level is 0 and wdiv_err is set. wdiv_err is cleared only by reset.
- R7: When bclk_master is 1, the word divider counts rising edges of the internal bit clock. When bclk_master is 0, it counts rising edges of bclk_in.
- R8: bclk_o equals the bit-clock level XOR bclk_inv, and wclk_o equals the word-clock level XOR wclk_inv.
- R9: bclk_oe is 1 only when bclk_master and bdiv_pwr are both 1. wclk_oe is 1 only when wclk_master and wdiv_pwr are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_tick | input | 1 | Edge tick of source 0 |
| adc_tick | input | 1 | Edge tick of source 1 |
| ndiv_tick | input | 1 | Edge tick of source 2 |
| src_sel | input | 2 | Divider source select |
| bdiv_pwr | input | 1 | Bit divider power enable |
| bdiv_code | input | 7 | Bit divider ratio code |
| wdiv_pwr | input | 1 | Word divider power enable |
| wdiv_code | input | 7 | Word divider ratio code |
| bclk_master | input | 1 | Bit clock line is master |
| wclk_master | input | 1 | Word clock line is master |
| bclk_inv | input | 1 | Invert bit clock output |
| wclk_inv | input | 1 | Invert word clock output |
| bclk_in | input | 1 | External bit clock, synchronous to clk |
| bclk_o | output | 1 | Bit clock output |
| bclk_oe | output | 1 | Bit clock pin drive enable |
| wclk_o | output | 1 | Word clock output |
| wclk_oe | output | 1 | Word clock pin drive enable |
| wdiv_err | output | 1 | Sticky reserved word-code flag |

## Verification
The clock levels and wdiv_err are registered, so they change on the edge that samples the tick, the bclk_in rise or the reserved code. They are visible one edge after that stimulus is applied. The inversion and output-enable results are combinational and are due in the same cycle as the stimulus. The bench drives inputs just after each rising edge and advances a behavioural model on that same rising edge. It compares every output at the following falling edge, so each result is sampled in the cycle where it is due. Measured periods and high times are counted in falling-edge samples between output transitions.

// File: rtl/serial_clock_master.sv
`timescale 1ns/1ps
module serial_clock_master #(
  parameter int CODE_W   = 7,
  parameter int MIN_WORD = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_tick,
  input  logic              adc_tick,
  input  logic              ndiv_tick,
  input  logic [1:0]        src_sel,
  input  logic              bdiv_pwr,
  input  logic [CODE_W-1:0] bdiv_code,
  input  logic              wdiv_pwr,
  input  logic [CODE_W-1:0] wdiv_code,
  input  logic              bclk_master,
  input  logic              wclk_master,
  input  logic              bclk_inv,
  input  logic              wclk_inv,
  input  logic              bclk_in,
  output logic              bclk_o,
  output logic              bclk_oe,
  output logic              wclk_o,
  output logic              wclk_oe,
  output logic              wdiv_err
);
  localparam int CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] FULL = {1'b1, {CODE_W{1'b0}}};
  localparam logic [CNT_W-1:0] MINW = CNT_W'(MIN_WORD);

  logic             src_tick;
  logic [CNT_W-1:0] b_ratio, w_ratio, w_low;
  logic [CNT_W-1:0] b_half, w_idx;
  logic             b_lvl, w_lvl, ext_prev;
  logic             w_reserved, b_wrap, b_rise, bit_edge;

  always_comb begin
    case (src_sel)
      2'b00:   src_tick = dac_tick;
      2'b01:   src_tick = adc_tick;
      2'b10:   src_tick = ndiv_tick;
      default: src_tick = 1'b0;
    endcase
  end

  assign b_ratio    = (bdiv_code == '0) ? FULL : {1'b0, bdiv_code};
  assign w_ratio    = (wdiv_code == '0) ? FULL : {1'b0, wdiv_code};
  assign w_low      = w_ratio - (w_ratio >> 1);
  assign w_reserved = (wdiv_code != '0) && ({1'b0, wdiv_code} < MINW);
  assign b_wrap     = src_tick && (b_half >= b_ratio - 1'b1);
  assign b_rise     = bdiv_pwr && b_wrap && !b_lvl;
  assign bit_edge   = bclk_master ? b_rise : (bclk_in && !ext_prev);

  always_ff @(posedge clk) begin
    if (!rst_n || !bdiv_pwr) begin
      b_half <= '0;
      b_lvl  <= 1'b0;
    end else if (src_tick) begin
      if (b_wrap) begin
        b_half <= '0;
        b_lvl  <= !b_lvl;
      end else begin
        b_half <= b_half + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= bclk_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     wdiv_err <= 1'b0;
    else if (wdiv_pwr && w_reserved) wdiv_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !wdiv_pwr || w_reserved) begin
      w_idx <= '0;
      w_lvl <= 1'b0;
    end else if (bit_edge) begin
      w_lvl <= (w_idx >= w_low);
      w_idx <= (w_idx >= w_ratio - 1'b1) ? '0 : w_idx + 1'b1;
    end
  end

  assign bclk_o  = b_lvl ^ bclk_inv;
  assign wclk_o  = w_lvl ^ wclk_inv;
  assign bclk_oe = bclk_master && bdiv_pwr;
  assign wclk_oe = wclk_master && wdiv_pwr;
endmodule

module serial_clock_master_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        src_sel,
  input logic              bdiv_pwr,
  input logic              wdiv_pwr,
  input logic [CODE_W-1:0] wdiv_code,
  input logic              bclk_inv,
  input logic              wclk_inv,
  input logic              bclk_o,
  input logic              wclk_o,
  input logic              wdiv_err
);
  logic code_res;
  assign code_res = (wdiv_code != '0) && (int'(wdiv_code) < 32);

  p_bit_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bdiv_pwr |=> !(bclk_o ^ bclk_inv));
  p_no_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bdiv_pwr && src_sel == 2'b11) |=> $stable(bclk_o ^ bclk_inv));
  p_word_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wdiv_pwr |=> !(wclk_o ^ wclk_inv));
  p_reserved_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdiv_pwr && code_res) |=> (wdiv_err && !(wclk_o ^ wclk_inv)));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdiv_err |=> wdiv_err);
endmodule

bind serial_clock_master serial_clock_master_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/serial_clock_master_test.sv
`timescale 1ns/1ps
module serial_clock_master_test;
  logic clk = 0, rst_n = 0;
  logic dac_tick = 0, adc_tick = 0, ndiv_tick = 0;
  logic [1:0] src_sel = 0;
  logic bdiv_pwr = 0, wdiv_pwr = 0;
  logic [6:0] bdiv_code = 7'h01, wdiv_code = 7'h40;
  logic bclk_master = 0, wclk_master = 0, bclk_inv = 0, wclk_inv = 0, bclk_in = 0;
  logic bclk_o, bclk_oe, wclk_o, wclk_oe, wdiv_err;

  serial_clock_master uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int dac_den = 1, adc_den = 1, ndiv_den = 1, ext_den = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick and external clock stimulus, just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    dac_tick  = (dac_den  > 0) && (cyc % dac_den  == 0);
    adc_tick  = (adc_den  > 0) && (cyc % adc_den  == 0);
    ndiv_tick = (ndiv_den > 0) && (cyc % ndiv_den == 0);
    if (ext_den > 0 && cyc % ext_den == 0) bclk_in = !bclk_in;
  end

  // behavioural reference
  int mh = 0, mw = 0;
  bit mb = 0, mwc = 0, merr = 0, mprev = 0;
  always @(posedge clk) begin
    int n, m;
    bit tk, rise, ev, res;
    if (!rst_n) begin
      mh = 0; mb = 0; mw = 0; mwc = 0; merr = 0; mprev = 0;
    end else begin
      tk = (src_sel == 0) ? dac_tick : (src_sel == 1) ? adc_tick :
           (src_sel == 2) ? ndiv_tick : 1'b0;
      n = (bdiv_code == 0) ? 128 : bdiv_code;
      rise = 0;
      if (!bdiv_pwr) begin mh = 0; mb = 0; end
      else if (tk) begin
        if (mh >= n - 1) begin mh = 0; mb = !mb; rise = mb; end
        else mh++;
      end
      ev = bclk_master ? rise : (bclk_in && !mprev);
      mprev = bclk_in;
      m = (wdiv_code == 0) ? 128 : wdiv_code;
      res = (wdiv_code != 0) && (wdiv_code < 32);
      if (wdiv_pwr && res) merr = 1;
      if (!wdiv_pwr || res) begin mw = 0; mwc = 0; end
      else if (ev) begin
        mwc = (mw >= m - m / 2);
        mw = (mw >= m - 1) ? 0 : mw + 1;
      end
    end
  end

  // per-cycle comparison and period measurement at the falling edge
  int b_rt = -1, bper = 0, w_rt = -1, wper = 0, whigh = 0, brises = 0;
  bit pb = 0, pw = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bclk_o == (mb ^ bclk_inv), "R3 bclk_o", bclk_o, mb ^ bclk_inv);
      check(wclk_o == (mwc ^ wclk_inv), "R5 wclk_o", wclk_o, mwc ^ wclk_inv);
      check(bclk_oe == (bclk_master & bdiv_pwr), "R9 bclk_oe", bclk_oe, bclk_master & bdiv_pwr);
      check(wclk_oe == (wclk_master & wdiv_pwr), "R9 wclk_oe", wclk_oe, wclk_master & wdiv_pwr);
      check(wdiv_err == merr, "R6 wdiv_err", wdiv_err, merr);
    end
    if (bclk_o && !pb) begin
      if (b_rt >= 0) bper = cyc - b_rt;
      b_rt = cyc; brises++;
    end
    if (wclk_o && !pw) begin
      if (w_rt >= 0) wper = cyc - w_rt;
      w_rt = cyc;
    end
    if (!wclk_o && pw && w_rt >= 0) whigh = cyc - w_rt;
    pb = bclk_o; pw = wclk_o;
  end

  task automatic clear_meas();
    b_rt = -1; bper = 0; w_rt = -1; wper = 0; whigh = 0; brises = 0;
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    step(4);
    @(negedge clk);
    check(!bclk_o && !wclk_o && !bclk_oe && !wclk_oe && !wdiv_err, "R1 reset outputs",
          {bclk_o, wclk_o, bclk_oe, wclk_oe, wdiv_err}, 0);
    step(1);
    rst_n = 1;
    step(2);
    @(negedge clk);
    check({bclk_o, wclk_o, bclk_oe, wclk_oe, wdiv_err} == 0, "R1 after release",
          {bclk_o, wclk_o, bclk_oe, wclk_oe, wdiv_err}, 0);

    step(1);
    bdiv_code = 3; bdiv_pwr = 1; bclk_master = 1; clear_meas();
    step(40);
    check(bper == 6, "R3 period N=3", bper, 6);
    check(bclk_oe == 1, "R9 master powered", bclk_oe, 1);

    src_sel = 1; adc_den = 2; clear_meas();
    step(80);
    check(bper == 12, "R2 adc source", bper, 12);

    src_sel = 2; ndiv_den = 1; bdiv_code = 0; clear_meas();
    step(700);
    check(bper == 256, "R3 code0=128", bper, 256);

    src_sel = 3; clear_meas();
    step(300);
    check(brises == 0, "R2 reserved source", brises, 0);

    bdiv_pwr = 0; src_sel = 0; bdiv_code = 1;
    step(2);
    bdiv_pwr = 1;
    wdiv_code = 7'h21; wdiv_pwr = 1; wclk_master = 1; clear_meas();
    step(300);
    check(wper == 66, "R5 frame M=33", wper, 66);
    check(whigh == 32, "R5 high M=33", whigh, 32);
    check(bper == 2, "R4 restart N=1", bper, 2);

    wdiv_pwr = 0; step(1); wdiv_code = 7'h40; wdiv_pwr = 1; clear_meas();
    step(500);
    check(wper == 128 && whigh == 64, "R5 M=64", wper, 128);

    wdiv_pwr = 0; step(1); wdiv_code = 0; wdiv_pwr = 1; clear_meas();
    step(800);
    check(wper == 256 && whigh == 128, "R5 code0=128", wper, 256);

    wdiv_code = 7'h10;
    step(50);
    @(negedge clk);
    check(wdiv_err == 1 && wclk_o == 0, "R6 reserved code", {wdiv_err, wclk_o}, 2);
    step(1);
    wdiv_code = 7'h20;
    step(20);
    @(negedge clk);
    check(wdiv_err == 1, "R6 sticky", wdiv_err, 1);

    step(1);
    bdiv_pwr = 0; wdiv_pwr = 0; bclk_inv = 1; wclk_inv = 1;
    step(2);
    @(negedge clk);
    check(bclk_o == 1 && wclk_o == 1, "R8 inverted idle", {bclk_o, wclk_o}, 3);
    step(1);
    bclk_inv = 0; wclk_inv = 0;

    bclk_master = 0; bdiv_pwr = 1; ext_den = 3;
    step(2);
    wdiv_code = 7'h20; wdiv_pwr = 1; clear_meas();
    step(600);
    check(wper == 192, "R7 slave bit clock", wper, 192);
    check(bclk_oe == 0, "R9 slave no drive", bclk_oe, 0);

    wdiv_pwr = 0;
    step(1);
    @(negedge clk);
    check(wclk_oe == 0, "R9 powered down float", wclk_oe, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule